// File: doc/BRIEF.md
# Program-Busy Status Read Logic

This block forms the byte returned to the host on every read of a nonvolatile array. While an internal program cycle runs, the array contents cannot be read. The block then returns a status pattern that carries two separate completion indicators. The top data bit reports the inverted top bit of the byte loaded last, but only when the host reads that same location. The bit below it flips on every new read access. All other bits are driven as zero while busy.

When the program cycle ends, the block passes the array's read data through unchanged. A read access starts on the rising edge of the combined strobe. That strobe is high when chip select and output enable are both active, so pulsing either one of them counts as a new access. The returned byte is registered, and it appears one clock after the inputs it was formed from. The start value and the end value of the flipping bit carry no meaning for the host; in this design the bit resets to zero and otherwise keeps its value while the block is idle.

Top module: `busy_status_read`

## Requirements
- R1: While reset is high, and at the first edge after it, `rd_data` is all zeros.
- R2: While busy, a read whose `rd_addr` equals `last_addr` returns the inverse of `last_data[7]` on `rd_data[7]`, one cycle after the inputs are presented.
- R3: While busy, a read at any other address returns 0 on `rd_data[7]`.
- R4: While busy, `rd_data[5:0]` are all 0.
- R5: While busy, `rd_data[6]` inverts once for each rising edge of the combined strobe (`chip_sel & out_en`). The new value shows in the cycle after the edge is sampled.
- R6: A new access may be made by pulsing `out_en` alone with `chip_sel` held high, or by pulsing `chip_sel` alone with `out_en` held high. Each of these advances bit 6 in the same way.
- R7: While busy, a strobe held high over several cycles, or held low, leaves `rd_data[6]` unchanged.
- R8: While idle, `rd_data` equals the `array_rdata` value sampled one cycle earlier.
- R9: While idle, strobe edges do not change the flip state. When busy is asserted again with no new edge, bit 6 shows the value it held when busy last ended.
- R10: If busy drops in the same cycle that a strobe edge is sampled, the output of that read is the true array data and the flip state does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_busy | input | 1 | High while a program cycle runs |
| last_addr | input | ADDR_W | Address of the byte loaded last |
| last_data | input | 8 | Value of the byte loaded last |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| rd_addr | input | ADDR_W | Address of the current read |
| array_rdata | input | 8 | Stored data from the array for `rd_addr` |
| rd_data | output | 8 | Registered read byte returned to the host |

## Verification
Two pairs of functions can land on the same clock edge. The end of a program cycle can meet a new read edge, and the start of a program cycle can meet a held strobe. The bench provokes the first pair by dropping `prog_busy` and raising the strobe in the same cycle. It then expects true array data and an unchanged flip bit when busy returns. It provokes the second pair by raising `prog_busy` with the strobe already high, and it expects bit 6 to keep the value it held before. Near-exhaustive sweeps over all 256 last-byte values and all 256 array values check the status fields and the pass-through arithmetically.

// File: rtl/busy_status_pkg.sv
package busy_status_pkg;

    localparam int BYTE_W = 8;
    localparam int POLL_BIT = BYTE_W - 1;
    localparam int FLIP_BIT = BYTE_W - 2;
    localparam int FILL_W = BYTE_W - 2;

    typedef enum logic [0:0] {
        MODE_PASS = 1'b0,
        MODE_STATUS = 1'b1
    } read_mode_e;

    typedef struct packed {
        read_mode_e mode;
        logic addr_hit;
        logic last_msb;
        logic flip;
    } status_ctl_t;

    function automatic logic [BYTE_W-1:0] status_byte(input status_ctl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[POLL_BIT] = c.addr_hit ? ~c.last_msb : 1'b0;
        b[FLIP_BIT] = c.flip;
        return b;
    endfunction

endpackage

// File: rtl/read_edge_detect.sv
module read_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic out_en,
    output logic new_read
);
    logic strobe;
    logic strobe_q;

    assign strobe = chip_sel & out_en;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else strobe_q <= strobe;
    end

    assign new_read = strobe & ~strobe_q;

    // R6
    single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        new_read |=> !new_read);

endmodule

// File: rtl/flip_state.sv
module flip_state (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic new_read,
    output logic flip_next
);
    logic flip_q;

    always_comb begin
        flip_next = flip_q;
        if (busy && new_read) flip_next = ~flip_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flip_q <= 1'b0;
        else flip_q <= flip_next;
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(flip_q));

    // R5
    busy_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && new_read) |=> (flip_q != $past(flip_q)));

    // R7
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !new_read |=> $stable(flip_q));

endmodule

// File: rtl/status_mux.sv
module status_mux
    import busy_status_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [BYTE_W-1:0] last_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] array_rdata,
    input  logic              flip,
    output logic [BYTE_W-1:0] byte_out
);
    status_ctl_t ctl;

    always_comb begin
        ctl.mode = busy ? MODE_STATUS : MODE_PASS;
        ctl.addr_hit = (rd_addr == last_addr);
        ctl.last_msb = last_data[POLL_BIT];
        ctl.flip = flip;
        byte_out = (ctl.mode == MODE_STATUS) ? status_byte(ctl) : array_rdata;
    end

endmodule

// File: rtl/busy_status_read.sv
module busy_status_read
    import busy_status_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [7:0]        last_data,
    input  logic              chip_sel,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_rdata,
    output logic [7:0]        rd_data
);
    logic              new_read;
    logic              flip_next;
    logic [BYTE_W-1:0] byte_next;

    read_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .chip_sel (chip_sel),
        .out_en   (out_en),
        .new_read (new_read)
    );

    flip_state u_flip (
        .clk       (clk),
        .rst       (rst),
        .busy      (prog_busy),
        .new_read  (new_read),
        .flip_next (flip_next)
    );

    status_mux #(.ADDR_W(ADDR_W)) u_mux (
        .busy        (prog_busy),
        .last_addr   (last_addr),
        .last_data   (last_data),
        .rd_addr     (rd_addr),
        .array_rdata (array_rdata),
        .flip        (flip_next),
        .byte_out    (byte_next)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else rd_data <= byte_next;
    end

    // R4
    fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        prog_busy |=> (rd_data[FILL_W-1:0] == '0));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_busy |=> (rd_data == $past(array_rdata)));

    // R2
    poll_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && rd_addr == last_addr) |=> (rd_data[POLL_BIT] != $past(last_data[POLL_BIT])));

    // R3
    poll_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && rd_addr != last_addr) |=> (rd_data[POLL_BIT] == 1'b0));

endmodule

// File: tb/tb_busy_status_read.sv
module tb_busy_status_read;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_busy = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0]    last_data = '0;
    logic          chip_sel = 1'b0;
    logic          out_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    array_rdata = '0;
    logic [7:0]    rd_data;

    int total = 0;
    int bad = 0;
    logic m_flip = 1'b0;
    logic m_prev = 1'b0;
    logic [7:0] m_exp = '0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    busy_status_read #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .prog_busy(prog_busy), .last_addr(last_addr),
        .last_data(last_data), .chip_sel(chip_sel), .out_en(out_en),
        .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic strobe;
        logic rise;
        @(posedge clk);
        strobe = chip_sel & out_en;
        rise = strobe & ~m_prev;
        m_prev = strobe;
        if (prog_busy && rise) m_flip = ~m_flip;
        if (prog_busy)
            m_exp = {(rd_addr == last_addr) ? ~last_data[7] : 1'b0, m_flip, 6'b0};
        else
            m_exp = array_rdata;
        @(negedge clk);
        chk(tag, rd_data, m_exp);
    endtask

    initial begin
        int limit;
        limit = 0;
        while (!done) begin
            @(posedge clk);
            limit++;
            if (limit > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] seen;
        // R1: output is cleared in reset
        repeat (3) @(negedge clk);
        chk("R1", rd_data, 8'h00);
        rst = 1'b0;

        // R8: idle pass-through sweep, strobe pulsing too
        for (int v = 0; v < 256; v++) begin
            array_rdata = 8'(v * 37 + 11);
            rd_addr = 16'(v);
            chip_sel = 1'b1;
            out_en = v[0];
            step("R8");
        end

        // R2 R4 R5: busy, matching address, every last-byte value
        prog_busy = 1'b1;
        last_addr = 16'h1234;
        rd_addr = 16'h1234;
        chip_sel = 1'b1;
        for (int v = 0; v < 256; v++) begin
            last_data = 8'(v);
            array_rdata = 8'(~v);
            out_en = 1'b1;
            step("R5");
            out_en = 1'b0;
            step("R2");
        end

        // R3 R4: mismatching addresses
        for (int v = 0; v < 64; v++) begin
            last_data = 8'(v * 5);
            rd_addr = 16'h1234 ^ 16'(v + 1);
            out_en = v[0];
            step("R3");
        end
        rd_addr = 16'h1234;

        // R6: chip select alone pulsing with output enable held high
        out_en = 1'b1;
        for (int v = 0; v < 16; v++) begin
            chip_sel = v[0];
            step("R6");
        end

        // R7: strobe held high, then held low
        chip_sel = 1'b1;
        out_en = 1'b1;
        step("R7");
        seen = rd_data;
        repeat (5) step("R7");
        chk("R7", {1'b0, rd_data[6], 6'b0}, {1'b0, seen[6], 6'b0});
        out_en = 1'b0;
        repeat (4) step("R7");

        // R10: busy ends in the same cycle a new edge is sampled
        step("R10");
        seen = rd_data;
        prog_busy = 1'b0;
        out_en = 1'b1;
        array_rdata = 8'h5A;
        step("R10");
        // R9: idle edges do not disturb the flip state
        for (int v = 0; v < 8; v++) begin
            out_en = v[0];
            array_rdata = 8'(v * 3);
            step("R9");
        end
        out_en = 1'b1;
        step("R9");
        prog_busy = 1'b1;
        step("R9");
        chk("R9", {1'b0, rd_data[6], 6'b0}, {1'b0, seen[6], 6'b0});

        // R1: reset in the middle of a busy phase
        rst = 1'b1;
        @(negedge clk);
        chk("R1", rd_data, 8'h00);
        rst = 1'b0;
        m_flip = 1'b0;
        m_prev = 1'b0;
        out_en = 1'b0;
        step("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule